// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is a target-only I2C interface that lets a bus controller read and write a small bank of 16-bit registers. It works out its own 7-bit bus address from two strap inputs. Each strap can be tied to one of four levels: ground, supply, the data line or the clock line. The upper three address bits are fixed at `100`. The two straps supply the lower four bits.

The block holds a register pointer. The first byte of every write transaction loads it. After that, the next two bytes go to the selected register, high byte first, and are committed in a single 16-bit strobe. A read transaction returns the register the pointer selects, high byte first, and does not resend the pointer.

The block watches synchronized copies of SCL and SDA. It pulls SDA low through an open-drain enable. Its storage sits behind a plain parallel port: a write strobe with index and data, and an index output with read data returned combinationally.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The target answers (ACK, SDA pulled low in the ninth clock) to the 7-bit address {`100`, A1 code, A0 code}. Each strap is coded as ground = `00`, supply = `01`, data line = `10`, clock line = `11`, with the A1 strap supplying address bits 3:2 and the A0 strap supplying bits 1:0. The R/W bit follows the address, and 1 means read.
- R2: An address that does not match gets no ACK. SDA stays released for the rest of that transfer, and no byte of it changes the pointer or any register.
- R3: The straps are decoded again at every START, so changing a strap between transactions changes the address that gets an answer.
- R4: In a write transaction, the first byte after the address is loaded into the pointer and ACKed. A transfer that ends after this byte, with STOP or repeated START, only updates the pointer and produces no write strobe.
- R5: The next two write bytes are each ACKed and form {high byte, low byte}. They produce exactly one single-cycle write strobe at the pointer index, after the low byte has been ACKed.
- R6: A write that ends after only the high data byte leaves every register unchanged and produces no strobe.
- R7: Pointer values at or above the number of registers are still ACKed. Writes through such a pointer produce no strobe, and reads return 0x0000.
- R8: A read sends the high byte, then the low byte, of the register the last stored pointer selects. The pointer keeps its value across any number of read transactions.
- R9: SDA is released after reset and after a controller NACK on a read byte, and it stays released until the next START.
- R10: A repeated START between a pointer write and a read begins a new address phase, and the read uses the pointer just written.
- R11: The SDA drive enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_a1_i | input | 1 | Upper address strap (address bits 3:2) |
| strap_a0_i | input | 1 | Lower address strap (address bits 1:0) |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_widx_o | output | $clog2(NUM_REGS) | Register index for the write |
| reg_wdata_o | output | 16 | Register write data |
| reg_ridx_o | output | $clog2(NUM_REGS) | Register index for the read |
| reg_rdata_i | input | 16 | Read data for reg_ridx_o |

## Verification
The hardest situation to reach is a strap tied to a bus line. Its decoded value depends on the line level in two separate bus phases around START, so the bench models the straps as wires that follow the live SCL and SDA nets and cycles all sixteen strap combinations. The bench also sends a wrong address in every combination. Because the straps change between transactions, an address decoded only once, or a line-tied strap mistaken for a fixed level, shows up as a missing or extra ACK. Truncated writes, out-of-range pointers and reads ended by a NACK after the first byte are driven as explicit bus sequences. The bench then reads back, through the normal read path, whatever state those sequences could have disturbed.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_st_e;

    typedef enum logic [2:0] {
        BY_ADDR,
        BY_PTR,
        BY_MSB,
        BY_LSB,
        BY_EXTRA
    } byte_e;

    localparam logic [2:0] ADDR_FIXED = 3'b100;

    function automatic logic [1:0] strap_code(input logic hi_start, input logic hi_low);
        case ({hi_start, hi_low})
            2'b00:   return 2'b00;
            2'b11:   return 2'b01;
            2'b01:   return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_strap_decode.sv
module i2c_strap_decode
    import i2c_ptr_pkg::*;
#(
    parameter int PINS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              rise_evt,
    input  logic [PINS-1:0]   pin_now,
    input  logic [PINS-1:0]   pin_prev,
    output logic [2*PINS-1:0] code_o
);
    typedef struct packed {
        logic [PINS-1:0]   p1;
        logic              pend;
        logic [2*PINS-1:0] code;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d = dec_q;
        if (start_evt) begin
            dec_d.p1   = pin_now;
            dec_d.pend = 1'b1;
        end else if (rise_evt && dec_q.pend) begin
            dec_d.pend = 1'b0;
            for (int i = 0; i < PINS; i++) begin
                dec_d.code[2*i +: 2] = strap_code(dec_q.p1[i], pin_prev[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign code_o = dec_q.code;

    AST_STRAP_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.pend && rise_evt && !start_evt) |=> !dec_q.pend); // R3
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
    import i2c_ptr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe_o,
    input  logic                        strap_a1_i,
    input  logic                        strap_a0_i,
    output logic                        reg_we_o,
    output logic [$clog2(NUM_REGS)-1:0] reg_widx_o,
    output logic [15:0]                 reg_wdata_o,
    output logic [$clog2(NUM_REGS)-1:0] reg_ridx_o,
    input  logic [15:0]                 reg_rdata_i
);
    localparam int IDX_W  = $clog2(NUM_REGS);
    localparam int PTR_W  = 8;
    localparam int WORD_W = 16;
    localparam logic [PTR_W-1:0] REG_LIMIT = PTR_W'(NUM_REGS);

    typedef struct packed {
        bus_st_e            st;
        byte_e              by;
        logic               rw;
        logic [3:0]         bitcnt;
        logic [7:0]         sh;
        logic [PTR_W-1:0]   ptr;
        logic [7:0]         msb;
        logic [WORD_W-1:0]  rword;
        logic               tx_lo;
        logic               mnack;
        logic               oe;
        logic               we;
        logic [IDX_W-1:0]   widx;
        logic [WORD_W-1:0]  wdata;
        logic               scl_p;
        logic               sda_p;
        logic [1:0]         strap_p;
    } slv_t;

    slv_t slv_d, slv_q;

    logic [3:0] sync_out;
    logic       scl_s, sda_s;
    logic [1:0] strap_s;
    logic [3:0] addr_lo;
    logic       rise_evt, fall_evt, start_evt, stop_evt, ptr_ok;
    logic [WORD_W-1:0] rd_word;

    i2c_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i, strap_a1_i, strap_a0_i}),
        .q_o   (sync_out)
    );

    assign scl_s   = sync_out[3];
    assign sda_s   = sync_out[2];
    assign strap_s = sync_out[1:0];

    assign rise_evt  = scl_s & ~slv_q.scl_p;
    assign fall_evt  = ~scl_s & slv_q.scl_p;
    assign start_evt = scl_s & slv_q.scl_p & slv_q.sda_p & ~sda_s;
    assign stop_evt  = scl_s & slv_q.scl_p & ~slv_q.sda_p & sda_s;

    i2c_strap_decode #(.PINS(2)) u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .rise_evt  (rise_evt),
        .pin_now   (strap_s),
        .pin_prev  (slv_q.strap_p),
        .code_o    (addr_lo)
    );

    assign ptr_ok  = slv_q.ptr < REG_LIMIT;
    assign rd_word = ptr_ok ? reg_rdata_i : '0;

    always_comb begin
        slv_d         = slv_q;
        slv_d.we      = 1'b0;
        slv_d.scl_p   = scl_s;
        slv_d.sda_p   = sda_s;
        slv_d.strap_p = strap_s;
        if (start_evt) begin
            slv_d.st     = ST_RX;
            slv_d.by     = BY_ADDR;
            slv_d.bitcnt = '0;
            slv_d.oe     = 1'b0;
        end else if (stop_evt) begin
            slv_d.st = ST_IDLE;
            slv_d.oe = 1'b0;
        end else begin
            case (slv_q.st)
                ST_RX: begin
                    if (rise_evt) begin
                        slv_d.sh     = {slv_q.sh[6:0], sda_s};
                        slv_d.bitcnt = slv_q.bitcnt + 4'd1;
                    end else if (fall_evt && slv_q.bitcnt == 4'd8) begin
                        if (slv_q.by != BY_ADDR) begin
                            slv_d.oe = 1'b1;
                            slv_d.st = ST_ACK;
                        end else if (slv_q.sh[7:1] == {ADDR_FIXED, addr_lo}) begin
                            slv_d.rw = slv_q.sh[0];
                            slv_d.oe = 1'b1;
                            slv_d.st = ST_ACK;
                        end else begin
                            slv_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (fall_evt) begin
                        slv_d.oe     = 1'b0;
                        slv_d.bitcnt = '0;
                        slv_d.st     = ST_RX;
                        case (slv_q.by)
                            BY_ADDR: begin
                                if (slv_q.rw) begin
                                    slv_d.rword = rd_word;
                                    slv_d.sh    = rd_word[15:8];
                                    slv_d.tx_lo = 1'b0;
                                    slv_d.oe    = ~rd_word[15];
                                    slv_d.st    = ST_TX;
                                end else begin
                                    slv_d.by = BY_PTR;
                                end
                            end
                            BY_PTR: begin
                                slv_d.ptr = slv_q.sh;
                                slv_d.by  = BY_MSB;
                            end
                            BY_MSB: begin
                                slv_d.msb = slv_q.sh;
                                slv_d.by  = BY_LSB;
                            end
                            BY_LSB: begin
                                slv_d.we    = ptr_ok;
                                slv_d.widx  = slv_q.ptr[IDX_W-1:0];
                                slv_d.wdata = {slv_q.msb, slv_q.sh};
                                slv_d.by    = BY_EXTRA;
                            end
                            default: slv_d.by = BY_EXTRA;
                        endcase
                    end
                end
                ST_TX: begin
                    if (fall_evt) begin
                        if (slv_q.bitcnt == 4'd7) begin
                            slv_d.oe = 1'b0;
                            slv_d.st = ST_MACK;
                        end else begin
                            slv_d.sh     = {slv_q.sh[6:0], 1'b0};
                            slv_d.oe     = ~slv_q.sh[6];
                            slv_d.bitcnt = slv_q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (rise_evt) begin
                        slv_d.mnack = sda_s;
                    end else if (fall_evt) begin
                        if (slv_q.mnack) begin
                            slv_d.st = ST_IDLE;
                        end else begin
                            slv_d.sh     = slv_q.tx_lo ? slv_q.rword[15:8] : slv_q.rword[7:0];
                            slv_d.oe     = slv_q.tx_lo ? ~slv_q.rword[15] : ~slv_q.rword[7];
                            slv_d.tx_lo  = ~slv_q.tx_lo;
                            slv_d.bitcnt = '0;
                            slv_d.st     = ST_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_q       <= '0;
            slv_q.scl_p <= 1'b1;
            slv_q.sda_p <= 1'b1;
        end else begin
            slv_q <= slv_d;
        end
    end

    assign sda_oe_o    = slv_q.oe;
    assign reg_we_o    = slv_q.we;
    assign reg_widx_o  = slv_q.widx;
    assign reg_wdata_o = slv_q.wdata;
    assign reg_ridx_o  = slv_q.ptr[IDX_W-1:0];

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slv_q.oe) |-> !slv_q.scl_p); // R11
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        slv_q.we |=> !slv_q.we); // R5
    AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slv_q.we |-> (slv_q.ptr < REG_LIMIT)); // R7
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_q.st == ST_IDLE) |-> !slv_q.oe); // R9
    AST_START_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_evt) |-> (slv_q.st == ST_RX && slv_q.by == BY_ADDR && !slv_q.oe)); // R10
    AST_ACK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_q.st == ST_ACK) |-> slv_q.oe); // R1
endmodule

// File: tb/i2c_ptr_slave_test.sv
`timescale 1ns/1ps
module i2c_ptr_slave_test;
    localparam int NREG = 8;
    localparam int Q    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic a1_pin, a0_pin;
    int   a1_t = 0;
    int   a0_t = 0;
    logic reg_we;
    logic [2:0] widx, ridx;
    logic [15:0] wdata, rdata;
    logic sda_line;
    logic [15:0] mem [NREG];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int mptr = 0;
    int exp_mem [NREG];
    int wq_idx [$];
    int wq_dat [$];
    logic oe_prev = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    always_comb begin
        case (a1_t)
            0: a1_pin = 1'b0;
            1: a1_pin = 1'b1;
            2: a1_pin = sda_line;
            default: a1_pin = scl_m;
        endcase
        case (a0_t)
            0: a0_pin = 1'b0;
            1: a0_pin = 1'b1;
            2: a0_pin = sda_line;
            default: a0_pin = scl_m;
        endcase
    end

    i2c_ptr_slave #(.NUM_REGS(NREG)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .strap_a1_i  (a1_pin),
        .strap_a0_i  (a0_pin),
        .reg_we_o    (reg_we),
        .reg_widx_o  (widx),
        .reg_wdata_o (wdata),
        .reg_ridx_o  (ridx),
        .reg_rdata_i (rdata)
    );

    assign rdata = mem[ridx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= 16'(16'h1000 + i * 16'h0101);
        end else if (reg_we) begin
            mem[widx] <= wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (wq_idx.size() == 0) begin
                    chk(1'b0, "R5 unexpected write strobe (R6/R7)", int'(widx), -1);
                end else begin
                    int ei, ed;
                    ei = wq_idx.pop_front();
                    ed = wq_dat.pop_front();
                    chk(int'(widx) == ei && int'(wdata) == ed, "R5 write strobe index/data",
                        {int'(widx), int'(wdata)}, (ei << 16) | ed);
                end
            end
            if (sda_oe != oe_prev) chk(scl_m == 1'b0, "R11 SDA drive changed with SCL high", int'(scl_m), 0);
            oe_prev <= sda_oe;
        end
    end

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b1; wait_q(2);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_m = b; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        s = sda_line; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = (s == 1'b0);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(give_ack ? 1'b0 : 1'b1, s);
    endtask

    function automatic int my_addr();
        return 64 + a1_t * 4 + a0_t;
    endfunction

    function automatic int model_word(input int p);
        return (p < NREG) ? exp_mem[p] : 0;
    endfunction

    task automatic do_write(input int p, input int n, input int data, input bit end_stop);
        bit ack;
        bus_start();
        send_byte(8'(my_addr() << 1), ack);
        chk(ack, "R1 R3 address ACK for strap-derived address", int'(ack), 1);
        send_byte(8'(p), ack);
        chk(ack, "R4 pointer byte ACK", int'(ack), 1);
        mptr = p;
        if (n >= 1) begin
            send_byte(8'(data >> 8), ack);
            chk(ack, "R5 high data byte ACK", int'(ack), 1);
        end
        if (n >= 2) begin
            if (p < NREG) begin
                exp_mem[p] = data & 16'hFFFF;
                wq_idx.push_back(p);
                wq_dat.push_back(data & 16'hFFFF);
            end
            send_byte(8'(data), ack);
            chk(ack, "R5 R7 low data byte ACK", int'(ack), 1);
        end
        if (end_stop) bus_stop();
    endtask

    task automatic do_read(input bit rstart, input string tag);
        bit ack;
        logic [7:0] hi, lo;
        int e;
        if (rstart) bus_rstart(); else bus_start();
        send_byte(8'((my_addr() << 1) | 1), ack);
        chk(ack, "R1 read address ACK", int'(ack), 1);
        recv_byte(1'b1, hi);
        recv_byte(1'b0, lo);
        e = model_word(mptr);
        chk({hi, lo} == 16'(e), tag, int'({hi, lo}), e);
        chk(sda_oe == 1'b0, "R9 SDA released after controller NACK", int'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic bad_addr_write(input int bad);
        bit ack;
        bus_start();
        send_byte(8'(bad << 1), ack);
        chk(!ack, "R2 R3 foreign address not ACKed", int'(ack), 0);
        send_byte(8'h07, ack);
        chk(!ack, "R2 byte after foreign address not ACKed", int'(ack), 0);
        bus_stop();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] b0, b1;
        for (int i = 0; i < NREG; i++) exp_mem[i] = 16'h1000 + i * 16'h0101;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R9 SDA released after reset", int'(sda_oe), 0);
        chk(reg_we == 1'b0, "R5 no strobe after reset", int'(reg_we), 0);

        // R1 R3: every strap combination, with a foreign address between
        for (int k = 0; k < 16; k++) begin
            a1_t = k / 4;
            a0_t = k % 4;
            do_write(k % NREG, 2, (k * 16'h1357) ^ 16'hA5C3, 1'b1);
            bad_addr_write(my_addr() ^ ((k % 2 == 0) ? 1 : 4));
            do_read(1'b0, "R8 R2 read of written register, pointer untouched by foreign address");
        end

        a1_t = 2;
        a0_t = 3;
        // R4 pointer-only write, R8 repeated reads reuse it
        do_write(3, 0, 0, 1'b1);
        do_read(1'b0, "R4 R8 read after pointer-only write");
        do_read(1'b0, "R8 second read without resending pointer");

        // R6 write ended after the high byte is discarded
        do_write(2, 1, 16'hDEAD, 1'b1);
        do_read(1'b0, "R6 register unchanged after truncated write");

        // R7 out-of-range pointers
        do_write(8'h20, 2, 16'hBEEF, 1'b1);
        do_read(1'b0, "R7 read at out-of-range pointer is zero");
        do_write(NREG, 2, 16'h1234, 1'b1);
        do_read(1'b0, "R7 read at first index past the bank is zero");
        do_write(NREG - 1, 0, 0, 1'b1);
        do_read(1'b0, "R7 last register unchanged by out-of-range write");

        // R9 NACK after the high byte ends the read
        do_write(5, 2, 16'h5AA5, 1'b1);
        bus_start();
        send_byte(8'((my_addr() << 1) | 1), ack);
        chk(ack, "R9 read address ACK", int'(ack), 1);
        recv_byte(1'b0, b0);
        chk(b0 == 8'h5A, "R8 high byte sent first", int'(b0), 8'h5A);
        chk(sda_oe == 1'b0, "R9 released after NACK on high byte", int'(sda_oe), 0);
        recv_byte(1'b0, b1);
        chk(b1 == 8'hFF, "R9 no drive after NACK until START", int'(b1), 8'hFF);
        bus_stop();

        // R10 repeated START between pointer write and read
        do_write(6, 0, 0, 1'b0);
        do_read(1'b1, "R10 read after repeated START uses new pointer");
        do_write(1, 2, 16'h0F0E, 1'b0);
        do_read(1'b1, "R10 R5 full write then repeated START read");

        repeat (20) @(negedge clk);
        chk(wq_idx.size() == 0, "R5 every expected write strobe seen", wq_idx.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule